// File: doc/BRIEF.md
# Real-Time Clock Hours Counter

This block keeps the hours field of a real-time clock as one packed-BCD byte. Each single-cycle pulse on the hour-tick input, which the minutes stage raises when it wraps, advances the byte by one hour. A mode bit held in a small control register chooses the count format. With the bit at 1 the byte counts as a 24-hour clock. With the bit at 0 it counts as a 12-hour clock, and bit 5 of the byte carries the afternoon flag.

In 12-hour format the byte does not count in a straight line. The hour after 11 in the morning is 0x32, which is noon. The hour after 0x31, which is 11 at night, is 0x12, which is midnight. The morning's twelve o'clock 0x12 steps to 0x01. When the day rolls over, the block raises a one-cycle day-carry pulse for the date logic. Software can load the byte directly through a write port. Changing the mode bit leaves the stored byte as it is, so software sets the mode first and then writes the time. A power-on reset clears the mode bit, which selects 12-hour format, and loads the byte with the midnight code of that format.

Top module: `rtc_hour_counter`

## Requirements
- R1: While `por_n` is low and after it is released, `mode_o` is 0, `hours_o` is 0x12 and `day_carry` is 0.
- R2: With `mode_o` at 1, each hour tick advances `hours_o` as a two-digit BCD count through 0x00..0x23. The units digit rolls from 9 to 0 and the tens digit increments.
- R3: With `mode_o` at 1, a tick at 0x23 loads 0x00. `day_carry` is high for exactly the one cycle in which 0x00 first appears.
- R4: With `mode_o` at 0, ticks step the morning codes 0x12, 0x01, 0x02 ... 0x09, 0x10, 0x11. A tick at 0x11 loads 0x32 and does not raise `day_carry`.
- R5: With `mode_o` at 0, ticks step the afternoon codes 0x32, 0x21 ... 0x29, 0x30, 0x31. Bit 5 (mask 0x20) stays set throughout.
- R6: With `mode_o` at 0, a tick at 0x31 loads 0x12. `day_carry` is high for exactly the one cycle in which 0x12 first appears.
- R7: `day_carry` is never high for two cycles in a row. Over 24 consecutive ticks in either mode it pulses exactly once.
- R8: When `wr_en` and `hour_tick` are both high in one cycle, the write wins. `hours_o` takes the written value on the next cycle, and `day_carry` stays 0 even when the written value is a wrap value.
- R9: A write stores bits 5..0 of `wr_data` unchanged. Bits 7 and 6 of `hours_o` always read 0.
- R10: A pulse on `mode_wr` loads `mode_sel` into `mode_o` on the next cycle and leaves `hours_o` unchanged.
- R11: In a cycle with neither `hour_tick` nor `wr_en`, `hours_o` holds its value and `day_carry` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hour_tick | input | 1 | One-cycle hour-advance pulse from the minutes stage |
| wr_en | input | 1 | Host write strobe for the hours byte |
| wr_data | input | 8 | Hours value to load, packed BCD |
| mode_wr | input | 1 | Write strobe for the mode bit |
| mode_sel | input | 1 | New mode bit: 1 selects 24-hour, 0 selects 12-hour |
| hours_o | output | 8 | Current hours byte |
| mode_o | output | 1 | Current mode bit |
| day_carry | output | 1 | One-cycle pulse when the day rolls over |

## Verification
The main check walks a whole day of ticks in each format and compares every step against an expected sequence. The 24-hour walk checks plain BCD digit carries and the 0x23 wrap. The 12-hour walk checks the jumps that do not count in a line: 0x12 to 0x01, 0x11 to 0x32, 0x32 to 0x21, 0x29 to 0x30 and 0x31 to 0x12. It also shows that the noon crossing raises no carry while midnight does. Directed patterns then drive a write in the same cycle as a tick, with wrap values as the written data, to separate write priority from counting. A write of a byte with its top bits set shows the masking. A mode change with no tick after it shows that the stored byte is never converted. An idle stretch and a reset in the middle of a run complete the set.

// File: rtl/rtc_hr_pkg.sv
`timescale 1ns/1ps
package rtc_hr_pkg;

   localparam int HR_BYTE_W = 8;
   localparam int BCD_DIG_W = 4;

   typedef logic [HR_BYTE_W-1:0] hr_byte_t;

   typedef struct packed {
      hr_byte_t value;
      logic     wrap;
   } hr_step_t;

   localparam hr_byte_t H24_LAST   = 8'h23;
   localparam hr_byte_t H24_FIRST  = 8'h00;
   localparam hr_byte_t H12_NIGHT  = 8'h12;
   localparam hr_byte_t H12_NOON   = 8'h32;
   localparam hr_byte_t H12_ELEVEN = 8'h11;
   localparam hr_byte_t H12_TWELVE = 8'h12;
   localparam hr_byte_t H12_ONE    = 8'h01;
   localparam hr_byte_t PM_MASK    = 8'h20;
   localparam hr_byte_t HOUR_MASK  = 8'h1F;
   localparam hr_byte_t STORE_MASK = 8'h3F;

   // two-digit BCD increment, tens digit taking the units carry
   function automatic hr_byte_t bcd_pair_inc(input hr_byte_t v);
      logic [BCD_DIG_W-1:0] units;
      logic [BCD_DIG_W-1:0] tens;
      units = v[BCD_DIG_W-1:0];
      tens  = v[HR_BYTE_W-1:BCD_DIG_W];
      if (units == 4'd9) begin
         units = 4'd0;
         tens  = tens + 4'd1;
      end else begin
         units = units + 4'd1;
      end
      return {tens, units};
   endfunction

endpackage

// File: rtl/rtc_hr_mode_reg.sv
`timescale 1ns/1ps
module rtc_hr_mode_reg
   import rtc_hr_pkg::*;
#(
   parameter bit MODE_RST = 1'b0
) (
   input  logic clk,
   input  logic por_n,
   input  logic mode_wr,
   input  logic mode_sel,
   output logic mode_q
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode_q <= MODE_RST;
      end else if (mode_wr) begin
         mode_q <= mode_sel;
      end
   end

endmodule

// File: rtl/rtc_hr_next.sv
`timescale 1ns/1ps
module rtc_hr_next
   import rtc_hr_pkg::*;
#(
   parameter bit SUPPORT_12H = 1'b1
) (
   input  hr_byte_t cur,
   input  logic     mode_24h,
   output hr_step_t step
);

   hr_step_t step24;
   hr_step_t step12;

   always_comb begin
      if (cur == H24_LAST) begin
         step24.value = H24_FIRST;
         step24.wrap  = 1'b1;
      end else begin
         step24.value = bcd_pair_inc(cur);
         step24.wrap  = 1'b0;
      end
   end

   generate
      if (SUPPORT_12H) begin : g_12h
         logic     pm;
         hr_byte_t hr;
         assign pm = |(cur & PM_MASK);
         assign hr = cur & HOUR_MASK;
         always_comb begin
            step12.wrap = 1'b0;
            if (hr == H12_ELEVEN) begin
               step12.value = pm ? H12_NIGHT : H12_NOON;
               step12.wrap  = pm;
            end else if (hr == H12_TWELVE) begin
               step12.value = H12_ONE | (pm ? PM_MASK : '0);
            end else begin
               step12.value = bcd_pair_inc(hr) | (pm ? PM_MASK : '0);
            end
         end
      end else begin : g_24_only
         assign step12 = step24;
      end
   endgenerate

   assign step = (mode_24h || !SUPPORT_12H) ? step24 : step12;

endmodule

// File: rtl/rtc_hr_store.sv
`timescale 1ns/1ps
module rtc_hr_store
   import rtc_hr_pkg::*;
#(
   parameter hr_byte_t RST_HOURS = 8'h12
) (
   input  logic     clk,
   input  logic     por_n,
   input  logic     tick,
   input  logic     wr_en,
   input  hr_byte_t wr_data,
   input  hr_step_t step,
   output hr_byte_t hours_q,
   output logic     carry_q
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hours_q <= RST_HOURS;
         carry_q <= 1'b0;
      end else begin
         carry_q <= 1'b0;
         if (wr_en) begin
            hours_q <= wr_data & STORE_MASK;
         end else if (tick) begin
            hours_q <= step.value;
            carry_q <= step.wrap;
         end
      end
   end

endmodule

// File: rtl/rtc_hour_counter.sv
`timescale 1ns/1ps
module rtc_hour_counter
   import rtc_hr_pkg::*;
#(
   parameter int       HOUR_W      = 8,
   parameter hr_byte_t RST_HOURS   = 8'h12,
   parameter bit       SUPPORT_12H = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hour_tick,
   input  logic              wr_en,
   input  logic [HOUR_W-1:0] wr_data,
   input  logic              mode_wr,
   input  logic              mode_sel,
   output logic [HOUR_W-1:0] hours_o,
   output logic              mode_o,
   output logic              day_carry
);

   generate
      if (HOUR_W != HR_BYTE_W) begin : g_bad_width
         $error("rtc_hour_counter: HOUR_W must equal the packed hours byte width");
      end
      if (RST_HOURS[7:6] != 2'b00) begin : g_bad_rst
         $error("rtc_hour_counter: RST_HOURS must keep bits 7 and 6 clear");
      end
   endgenerate

   hr_byte_t cur_q;
   hr_step_t nxt;

   rtc_hr_mode_reg #(.MODE_RST(1'b0)) mode_i (
      .clk      (clk),
      .por_n    (por_n),
      .mode_wr  (mode_wr),
      .mode_sel (mode_sel),
      .mode_q   (mode_o)
   );

   rtc_hr_next #(.SUPPORT_12H(SUPPORT_12H)) next_i (
      .cur      (cur_q),
      .mode_24h (mode_o),
      .step     (nxt)
   );

   rtc_hr_store #(.RST_HOURS(RST_HOURS)) store_i (
      .clk      (clk),
      .por_n    (por_n),
      .tick     (hour_tick),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .step     (nxt),
      .hours_q  (cur_q),
      .carry_q  (day_carry)
   );

   assign hours_o = cur_q;

endmodule

// File: rtl/rtc_hour_counter_chk.sv
`timescale 1ns/1ps
module rtc_hour_counter_chk (
   input logic       clk,
   input logic       por_n,
   input logic       hour_tick,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] hours_o,
   input logic       mode_o,
   input logic       day_carry
);

   assert_carry_single_R7: assert property (@(posedge clk) disable iff (!por_n)
      day_carry |=> !day_carry);

   // R3 and R6: carry only after an accepted tick, landing on the wrap code of the old mode
   assert_carry_wrap_R3: assert property (@(posedge clk) disable iff (!por_n)
      day_carry |-> ($past(hour_tick) && !$past(wr_en) &&
                     (($past(mode_o) && hours_o == 8'h00) ||
                      (!$past(mode_o) && hours_o == 8'h12))));

   assert_write_wins_R8: assert property (@(posedge clk) disable iff (!por_n)
      wr_en |=> (hours_o == ($past(wr_data) & 8'h3F)) && !day_carry);

   assert_top_bits_zero_R9: assert property (@(posedge clk) disable iff (!por_n)
      hours_o[7:6] == 2'b00);

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
      (!hour_tick && !wr_en) |=> ($stable(hours_o) && !day_carry));

endmodule

bind rtc_hour_counter rtc_hour_counter_chk chk_i (
   .clk       (clk),
   .por_n     (por_n),
   .hour_tick (hour_tick),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .hours_o   (hours_o),
   .mode_o    (mode_o),
   .day_carry (day_carry)
);

// File: tb/rtc_hour_counter_tb.sv
`timescale 1ns/1ps
module rtc_hour_counter_tb_top;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       hour_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       mode_wr = 1'b0;
   logic       mode_sel = 1'b0;
   logic [7:0] hours_o;
   logic       mode_o;
   logic       day_carry;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   rtc_hour_counter dut_i (
      .clk       (clk),
      .por_n     (por_n),
      .hour_tick (hour_tick),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .mode_wr   (mode_wr),
      .mode_sel  (mode_sel),
      .hours_o   (hours_o),
      .mode_o    (mode_o),
      .day_carry (day_carry)
   );

   // {mode, expected carry, expected hours} after each tick
   localparam logic [9:0] VEC [48] = '{
      10'h201, 10'h202, 10'h203, 10'h204, 10'h205, 10'h206, 10'h207, 10'h208,
      10'h209, 10'h210, 10'h211, 10'h212, 10'h213, 10'h214, 10'h215, 10'h216,
      10'h217, 10'h218, 10'h219, 10'h220, 10'h221, 10'h222, 10'h223, 10'h300,
      10'h001, 10'h002, 10'h003, 10'h004, 10'h005, 10'h006, 10'h007, 10'h008,
      10'h009, 10'h010, 10'h011, 10'h032, 10'h021, 10'h022, 10'h023, 10'h024,
      10'h025, 10'h026, 10'h027, 10'h028, 10'h029, 10'h030, 10'h031, 10'h112
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic do_tick();
      @(negedge clk) hour_tick = 1'b1;
      @(negedge clk) hour_tick = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] v, input logic with_tick);
      @(negedge clk) begin wr_en = 1'b1; wr_data = v; hour_tick = with_tick; end
      @(negedge clk) begin wr_en = 1'b0; hour_tick = 1'b0; end
   endtask

   task automatic set_mode(input logic m);
      @(negedge clk) begin mode_wr = 1'b1; mode_sel = m; end
      @(negedge clk) mode_wr = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      int carries;
      repeat (3) @(negedge clk);
      check("R1 hours in reset", {24'd0, hours_o}, 32'h12);
      check("R1 mode in reset", {31'd0, mode_o}, 32'h0);
      por_n = 1'b1;
      @(negedge clk);
      check("R1 hours after reset", {24'd0, hours_o}, 32'h12);
      check("R1 mode after reset", {31'd0, mode_o}, 32'h0);
      check("R1 carry after reset", {31'd0, day_carry}, 32'h0);

      // full day in 24-hour format, then in 12-hour format
      carries = 0;
      for (int i = 0; i < 48; i++) begin
         if (i == 0) begin
            set_mode(1'b1);
            check("R10 mode set to 24h", {31'd0, mode_o}, 32'h1);
            do_write(8'h00, 1'b0);
         end
         if (i == 24) begin
            check("R7 one carry per 24h day", carries, 32'd1);
            carries = 0;
            set_mode(1'b0);
            do_write(8'h12, 1'b0);
         end
         do_tick();
         if (day_carry) carries++;
         check(VEC[i][9] ? "R2/R3 24h step" : "R4/R5/R6 12h step",
               {24'd0, hours_o}, {24'd0, VEC[i][7:0]});
         check(VEC[i][9] ? "R3/R7 24h carry" : "R4/R6/R7 12h carry",
               {31'd0, day_carry}, {31'd0, VEC[i][8]});
         @(negedge clk);
         check("R7 carry lasts one cycle", {31'd0, day_carry}, 32'h0);
      end
      check("R7 one carry per 12h day", carries, 32'd1);

      // R8: write beats tick, even with wrap codes
      set_mode(1'b1);
      do_write(8'h05, 1'b1);
      check("R8 write over tick", {24'd0, hours_o}, 32'h05);
      do_write(8'h23, 1'b1);
      check("R8 write 0x23 over tick", {24'd0, hours_o}, 32'h23);
      check("R8 no carry on write", {31'd0, day_carry}, 32'h0);
      do_tick();
      check("R3 tick after written 0x23", {24'd0, hours_o}, 32'h00);
      check("R3 carry after written 0x23", {31'd0, day_carry}, 32'h1);
      set_mode(1'b0);
      do_write(8'h31, 1'b1);
      check("R8 write 0x31 over tick in 12h", {24'd0, hours_o}, 32'h31);
      check("R8 no carry on 12h write", {31'd0, day_carry}, 32'h0);

      // R9: top bits masked, rest kept
      do_write(8'hFF, 1'b0);
      check("R9 write 0xFF", {24'd0, hours_o}, 32'h3F);
      do_write(8'h94, 1'b0);
      check("R9 write 0x94", {24'd0, hours_o}, 32'h14);

      // R10: mode change does not convert
      set_mode(1'b1);
      do_write(8'h15, 1'b0);
      set_mode(1'b0);
      check("R10 mode now 12h", {31'd0, mode_o}, 32'h0);
      check("R10 hours kept after mode change", {24'd0, hours_o}, 32'h15);
      set_mode(1'b1);
      check("R10 hours kept after mode back", {24'd0, hours_o}, 32'h15);

      // R11: idle hold
      repeat (5) @(negedge clk);
      check("R11 idle hold", {24'd0, hours_o}, 32'h15);
      check("R11 no carry when idle", {31'd0, day_carry}, 32'h0);

      // R1: reset in the middle of a run
      @(negedge clk) por_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset hours", {24'd0, hours_o}, 32'h12);
      check("R1 mid-run reset mode", {31'd0, mode_o}, 32'h0);
      por_n = 1'b1;
      do_tick();
      check("R4 first tick after reset", {24'd0, hours_o}, 32'h01);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule